// File: doc/BRIEF.md
# Packed SIMD Compare Execution Unit

This unit executes packed integer compares on two 64-bit operands. A decoded opcode byte selects the operation: equality or signed greater-than, on lanes 8, 16 or 32 bits wide. Each destination lane becomes all ones when its compare holds and all zeros when it does not. The result goes back to the register slot of the first operand. The second operand only supplies data.

Before any result is written, the processor-state inputs are checked. These are the emulation and task-switched control bits, the packed-integer feature bit and a pending unmasked floating-point exception. If a check fails, the unit reports a 2-bit fault code and suppresses the writeback. One output register holds the result under a valid/ready handshake, so a stalled consumer freezes the output and stops further input from being accepted. The unit has no flags output, so a compare cannot alter status flags.

Top module: `simd_cmp_unit`

## Requirements
- R1: Opcodes 0x64, 0x65 and 0x66 compare signed two's-complement lanes of 8, 16 and 32 bits. A lane is all ones when the first operand's lane is strictly greater than the second's. Otherwise it is all zeros, including when the two lanes are equal.
- R2: Opcodes 0x74, 0x75 and 0x76 compare 8-, 16- and 32-bit lanes for equality. A lane is all ones when the two lanes are equal and all zeros when they differ.
- R3: Any other opcode byte gives fault code 1 (invalid opcode).
- R4: When `ctl_emulate` is 1, the fault code is 1.
- R5: When `feat_pkint` (feature word bit 23) is 0, the fault code is 1.
- R6: When `ctl_task_sw` is 1, the fault code is 2 (device not available).
- R7: When `fp_pend` is 1, the fault code is 3 (floating-point exception pending).
- R8: When several fault causes are present, only the highest-priority one is reported. Code 1 ranks first, then code 2, then code 3. Code 0 means no fault.
- R9: A faulted operation drives `out_wr_en` 0 and `out_data` all zeros.
- R10: A fault-free operation drives `out_wr_en` 1 with `out_wr_idx` equal to the `in_dst_idx` that was accepted.
- R11: An input is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. Its result, fault code and `out_valid` appear after that same edge.
- R12: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values and `in_ready` is 0.
- R13: After reset, `out_valid`, `out_wr_en`, `out_fault` and `out_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_opcode | input | 8 | Second opcode byte |
| in_src_a | input | 64 | First operand (destination) |
| in_src_b | input | 64 | Second operand |
| in_dst_idx | input | 3 | Register slot of the first operand |
| ctl_emulate | input | 1 | Emulation control bit |
| ctl_task_sw | input | 1 | Task-switched control bit |
| feat_pkint | input | 1 | Packed-integer feature bit (feature word bit 23) |
| fp_pend | input | 1 | Unmasked floating-point exception pending |
| out_valid | output | 1 | Result register holds an operation |
| out_ready | input | 1 | Consumer takes the result |
| out_wr_en | output | 1 | Write the result to the register slot |
| out_wr_idx | output | 3 | Destination register slot |
| out_data | output | 64 | Compare result |
| out_fault | output | 2 | Fault code: 0 none, 1 invalid opcode, 2 device not available, 3 floating-point pending |

## Verification
Every result and fault code is due in the output register one clock edge after acceptance. The bench drives each input on a falling edge, lets one rising edge pass and samples on the following falling edge, which keeps every sample half a period away from the edge that loads the register. For the stall case, the bench holds `out_ready` low across several further falling edges and compares the outputs each time. It then raises `out_ready`, lets one more rising edge pass and confirms that the waiting operation has loaded.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

  localparam int FLT_W = 2;

  localparam logic [7:0] OP_GT8  = 8'h64;
  localparam logic [7:0] OP_GT16 = 8'h65;
  localparam logic [7:0] OP_GT32 = 8'h66;
  localparam logic [7:0] OP_EQ8  = 8'h74;
  localparam logic [7:0] OP_EQ16 = 8'h75;
  localparam logic [7:0] OP_EQ32 = 8'h76;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE   = 2'd0,
    FLT_BADOP  = 2'd1,
    FLT_NODEV  = 2'd2,
    FLT_FPPEND = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2
  } lane_w_e;

  typedef struct packed {
    logic    legal;
    logic    is_eq;
    lane_w_e lw;
  } dec_t;

endpackage

// File: rtl/simd_cmp_decode.sv
module simd_cmp_decode
  import simd_cmp_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec = '{legal: 1'b0, is_eq: 1'b0, lw: LW_8};
    case (opcode)
      OP_GT8:  dec = '{legal: 1'b1, is_eq: 1'b0, lw: LW_8};
      OP_GT16: dec = '{legal: 1'b1, is_eq: 1'b0, lw: LW_16};
      OP_GT32: dec = '{legal: 1'b1, is_eq: 1'b0, lw: LW_32};
      OP_EQ8:  dec = '{legal: 1'b1, is_eq: 1'b1, lw: LW_8};
      OP_EQ16: dec = '{legal: 1'b1, is_eq: 1'b1, lw: LW_16};
      OP_EQ32: dec = '{legal: 1'b1, is_eq: 1'b1, lw: LW_32};
      default: dec = '{legal: 1'b0, is_eq: 1'b0, lw: LW_8};
    endcase
  end

endmodule

// File: rtl/simd_cmp_fault.sv
module simd_cmp_fault
  import simd_cmp_pkg::*;
(
  input  logic   bad_op,
  input  logic   emulate,
  input  logic   feat_ok,
  input  logic   task_sw,
  input  logic   fp_pend,
  output fault_e fault
);

  // Priority chain: invalid opcode, then device unavailable, then fp pending.
  always_comb begin
    if (bad_op || emulate || !feat_ok) fault = FLT_BADOP;
    else if (task_sw)                  fault = FLT_NODEV;
    else if (fp_pend)                  fault = FLT_FPPEND;
    else                               fault = FLT_NONE;
  end

endmodule

// File: rtl/simd_cmp_lanes.sv
module simd_cmp_lanes
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  dec_t              dec,
  output logic [DATA_W-1:0] res
);

  localparam int NUM_W = 3;

  logic [DATA_W-1:0] eq_mask [NUM_W];
  logic [DATA_W-1:0] gt_mask [NUM_W];

  for (genvar gw = 0; gw < NUM_W; gw++) begin : g_width
    localparam int LW    = 8 << gw;
    localparam int LANES = DATA_W / LW;
    logic [DATA_W-1:0] eq_v;
    logic [DATA_W-1:0] gt_v;
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      logic signed [LW-1:0] la;
      logic signed [LW-1:0] lb;
      assign la = src_a[gl*LW +: LW];
      assign lb = src_b[gl*LW +: LW];
      assign eq_v[gl*LW +: LW] = {LW{la == lb}};
      assign gt_v[gl*LW +: LW] = {LW{la > lb}};
    end
    assign eq_mask[gw] = eq_v;
    assign gt_mask[gw] = gt_v;
  end

  always_comb begin
    case (dec.lw)
      LW_8:    res = dec.is_eq ? eq_mask[0] : gt_mask[0];
      LW_16:   res = dec.is_eq ? eq_mask[1] : gt_mask[1];
      LW_32:   res = dec.is_eq ? eq_mask[2] : gt_mask[2];
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/simd_cmp_unit.sv
module simd_cmp_unit
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [DATA_W-1:0] in_src_a,
  input  logic [DATA_W-1:0] in_src_b,
  input  logic [IDX_W-1:0]  in_dst_idx,
  input  logic              ctl_emulate,
  input  logic              ctl_task_sw,
  input  logic              feat_pkint,
  input  logic              fp_pend,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr_en,
  output logic [IDX_W-1:0]  out_wr_idx,
  output logic [DATA_W-1:0] out_data,
  output logic [FLT_W-1:0]  out_fault
);

  dec_t              dec;
  fault_e            fault;
  logic [DATA_W-1:0] cmp_res;
  logic              accept;

  simd_cmp_decode u_dec (
    .opcode (in_opcode),
    .dec    (dec)
  );

  simd_cmp_fault u_flt (
    .bad_op  (!dec.legal),
    .emulate (ctl_emulate),
    .feat_ok (feat_pkint),
    .task_sw (ctl_task_sw),
    .fp_pend (fp_pend),
    .fault   (fault)
  );

  simd_cmp_lanes #(.DATA_W(DATA_W)) u_lanes (
    .src_a (in_src_a),
    .src_b (in_src_b),
    .dec   (dec),
    .res   (cmp_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_wr_en  <= 1'b0;
      out_wr_idx <= '0;
      out_data   <= '0;
      out_fault  <= FLT_NONE;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_wr_en  <= (fault == FLT_NONE);
      out_wr_idx <= in_dst_idx;
      out_data   <= (fault == FLT_NONE) ? cmp_res : '0;
      out_fault  <= fault;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
      out_wr_en  <= 1'b0;
    end
  end

endmodule

// File: rtl/simd_cmp_unit_chk.sv
module simd_cmp_unit_chk
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_opcode,
  input logic              ctl_emulate,
  input logic              ctl_task_sw,
  input logic              feat_pkint,
  input logic              fp_pend,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_wr_en,
  input logic [IDX_W-1:0]  out_wr_idx,
  input logic [DATA_W-1:0] out_data,
  input logic [FLT_W-1:0]  out_fault
);

  logic take;
  logic op_ok;
  assign take  = in_valid && in_ready;
  assign op_ok = (in_opcode == OP_GT8) || (in_opcode == OP_GT16) ||
                 (in_opcode == OP_GT32) || (in_opcode == OP_EQ8) ||
                 (in_opcode == OP_EQ16) || (in_opcode == OP_EQ32);

  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_fault) && $stable(out_wr_en) && $stable(out_wr_idx));

  // R12
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R9
  fault_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_fault != FLT_NONE) |-> !out_wr_en && (out_data == '0));

  // R4
  emulate_chk: assert property (@(posedge clk) disable iff (rst)
    take && ctl_emulate |=> out_fault == FLT_BADOP);

  // R8
  nodev_prio_chk: assert property (@(posedge clk) disable iff (rst)
    take && op_ok && !ctl_emulate && feat_pkint && ctl_task_sw
      |=> out_fault == FLT_NODEV);

  // R7
  fppend_chk: assert property (@(posedge clk) disable iff (rst)
    take && op_ok && !ctl_emulate && feat_pkint && !ctl_task_sw && fp_pend
      |=> out_fault == FLT_FPPEND);

  // R1 R2: every byte of a result is a full mask
  for (genvar gb = 0; gb < DATA_W/8; gb++) begin : g_byte
    byte_mask_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_data[gb*8 +: 8] == 8'h00) || (out_data[gb*8 +: 8] == 8'hFF));
  end

endmodule

bind simd_cmp_unit simd_cmp_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_opcode   (in_opcode),
  .ctl_emulate (ctl_emulate),
  .ctl_task_sw (ctl_task_sw),
  .feat_pkint  (feat_pkint),
  .fp_pend     (fp_pend),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_wr_en   (out_wr_en),
  .out_wr_idx  (out_wr_idx),
  .out_data    (out_data),
  .out_fault   (out_fault)
);

// File: tb/simd_cmp_unit_test.sv
module simd_cmp_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = 8'h00;
  logic [63:0] in_src_a = '0;
  logic [63:0] in_src_b = '0;
  logic [2:0]  in_dst_idx = '0;
  logic        ctl_emulate = 1'b0;
  logic        ctl_task_sw = 1'b0;
  logic        feat_pkint = 1'b1;
  logic        fp_pend = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_wr_en;
  logic [2:0]  out_wr_idx;
  logic [63:0] out_data;
  logic [1:0]  out_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  simd_cmp_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_dst_idx(in_dst_idx), .ctl_emulate(ctl_emulate), .ctl_task_sw(ctl_task_sw),
    .feat_pkint(feat_pkint), .fp_pend(fp_pend), .out_valid(out_valid),
    .out_ready(out_ready), .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx),
    .out_data(out_data), .out_fault(out_fault)
  );

  function automatic logic [63:0] ref_cmp(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
    int w;
    logic [63:0] r;
    w = 8 << (op[2:0] - 3'd4);
    r = '0;
    for (int i = 0; i < 64; i += w) begin
      logic [31:0] la, lb, sb;
      logic hit;
      la = '0; lb = '0;
      for (int k = 0; k < w; k++) begin la[k] = a[i+k]; lb[k] = b[i+k]; end
      sb = 32'd1 << (w - 1);
      hit = op[4] ? (la == lb) : ((la ^ sb) > (lb ^ sb));
      if (hit) for (int k = 0; k < w; k++) r[i+k] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [2:0] idx, input logic em, input logic ts,
                       input logic ft, input logic fp);
    @(negedge clk);
    in_opcode = op; in_src_a = a; in_src_b = b; in_dst_idx = idx;
    ctl_emulate = em; ctl_task_sw = ts; feat_pkint = ft; fp_pend = fp;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [7:0] op, input logic [63:0] a,
                           input logic [63:0] b, input logic [2:0] idx);
    issue(op, a, b, idx, 1'b0, 1'b0, 1'b1, 1'b0);
    chk({tag, " data"}, out_data, ref_cmp(op, a, b));
    chk({tag, " R10 wr_en"}, {63'd0, out_wr_en}, 64'd1);
    chk({tag, " R10 wr_idx"}, {61'd0, out_wr_idx}, {61'd0, idx});
    chk({tag, " R11 valid/fault"}, {61'd0, out_valid, out_fault}, 64'h4);
  endtask

  task automatic expect_flt(input string tag, input logic [7:0] op, input logic em,
                            input logic ts, input logic ft, input logic fp, input logic [1:0] code);
    issue(op, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 3'd5, em, ts, ft, fp);
    chk({tag, " fault"}, {62'd0, out_fault}, {62'd0, code});
    chk({tag, " R9 no write"}, {out_data[62:0], out_wr_en}, 64'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13 reset outputs", {out_data[60:0], out_valid, out_wr_en, |out_fault}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_greater();
    expect_ok("R1 gt8 mixed", 8'h64, 64'h7F80_0001_FF05_0580, 64'h807F_FF00_0005_0481, 3'd1);
    expect_ok("R1 gt8 equal", 8'h64, 64'hA5A5_A5A5_A5A5_A5A5, 64'hA5A5_A5A5_A5A5_A5A5, 3'd2);
    expect_ok("R1 gt16 sign", 8'h65, 64'h8000_7FFF_0000_FFFF, 64'h7FFF_8000_FFFF_0000, 3'd3);
    expect_ok("R1 gt32 sign", 8'h66, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 3'd4);
    expect_ok("R1 gt32 equal", 8'h66, 64'h0000_0010_FFFF_FFF0, 64'h0000_0010_FFFF_FFEF, 3'd7);
  endtask

  task automatic t_equal();
    expect_ok("R2 eq8", 8'h74, 64'h0011_2233_4455_6677, 64'h0011_2234_4455_6676, 3'd0);
    expect_ok("R2 eq16", 8'h75, 64'hFFFF_0000_1234_8000, 64'hFFFF_0001_1234_8000, 3'd6);
    expect_ok("R2 eq32", 8'h76, 64'hDEAD_BEEF_0000_0000, 64'hDEAD_BEEF_0000_0100, 3'd2);
  endtask

  task automatic t_faults();
    expect_flt("R3 bad opcode 0x67", 8'h67, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1);
    expect_flt("R3 bad opcode 0x00", 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1);
    expect_flt("R4 emulate", 8'h75, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1);
    expect_flt("R5 feature clear", 8'h64, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    expect_flt("R6 task switched", 8'h66, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2);
    expect_flt("R7 fp pending", 8'h74, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3);
  endtask

  task automatic t_priority();
    expect_flt("R8 emulate over others", 8'h65, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1);
    expect_flt("R8 feature over task", 8'h65, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1);
    expect_flt("R8 bad op over task", 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1);
    expect_flt("R8 task over fp", 8'h76, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2);
  endtask

  task automatic t_stall();
    logic [63:0] first;
    first = ref_cmp(8'h65, 64'h0005_FFFB_0000_7000, 64'h0004_FFFC_0000_6FFF);
    @(negedge clk);
    out_ready = 1'b0;
    issue(8'h65, 64'h0005_FFFB_0000_7000, 64'h0004_FFFC_0000_6FFF, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R11 stalled result", out_data, first);
    in_opcode = 8'h74; in_src_a = '1; in_src_b = '1; in_dst_idx = 3'd6;
    in_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R12 held data", out_data, first);
      chk("R12 held idx/ready", {60'd0, out_wr_idx, in_ready}, {60'd0, 3'd3, 1'b0});
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12 released next op", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R12 released idx", {61'd0, out_wr_idx}, 64'd6);
    @(negedge clk);
    chk("R11 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_greater();
    t_equal();
    t_faults();
    t_priority();
    t_stall();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule